// File: doc/BRIEF.md
# Decimal Operand Address Resolver

This unit turns the address field of an instruction operand into an effective address. The field has four characters. Each one holds a decimal digit in its low four bits. A separate three-bit field gives the ten-thousands digit, and it is stored bit-inverted. A common/partition bit and an active-low indirect flag come with the field, along with a two-bit selector that picks an index register or no indexing.

When indirection is requested, the unit reads four characters at the given address, most significant digit first. Those characters replace the original address, including the zone bits that carry the ten-thousands field and the common bit. Indirection goes one level only. After that, an index register may be added. The index register is a four-digit decimal value held in the partition. The sum uses only the numeric bits, wraps modulo 10000, and never changes the ten-thousands digit.

The unit reads memory through a simple request/response port and returns a five-digit decimal address, a common flag, an error flag for non-decimal digits and a one-cycle done strobe.

Top module: `dafu_top`

## Requirements
- R1: During and right after reset, `done`, `mem_rd`, `eff_common`, `eff_err` and `eff_addr` are all zero.
- R2: A direct, unindexed request (`ind_n`=1, `idx_sel`=0) yields `eff_addr` whose low four digits are bits [3:0] of the four characters. The character in `addr_chars[23:18]` is the most significant digit. The request makes no memory read, and `eff_common` equals `common`.
- R3: The ten-thousands digit `eff_addr[19:16]` is the bitwise inverse of `tt_inv`, so 111 gives 0 and 010 gives 5.
- R4: When `ind_n`=0, the unit makes exactly four reads. They go to the base address plus 0, 1, 2 and 3, with the four-digit part wrapping modulo 10000. Each read keeps the request's ten-thousands digit and common bit.
- R5: The four fetched characters, in read order, become the new digits. The inverted bit 4 of fetched characters 0, 1 and 2 gives ten-thousands weights 4, 2 and 1. Bit 5 of fetched character 3 gives the new common bit. No further indirection follows, whatever the fetched bits hold.
- R6: `idx_sel`=s, where s is 1 to 3, makes four more reads, after any indirect reads. They go to partition addresses 00s1 to 00s4 (common 0, ten-thousands 0), most significant digit first. `idx_sel`=0 makes no index reads.
- R7: Indexing adds the four index digits (bits [3:0] of each character, with bits 4 and 5 ignored) to the four address digits in decimal modulo 10000. The ten-thousands digit and the common bit are unchanged: 1000+0005 gives 1005, and 43560+8000 gives 41560.
- R8: An unindexed address digit above 9 passes through unchanged. `eff_err` is 1 with `done` whenever any final address digit, or any index digit used, is above 9. Otherwise it is 0.
- R9: `start` is ignored while a request is in progress. Each accepted request produces exactly one `done`.
- R10: `mem_rd` and `done` are each high for a single cycle at a time.
- R11: `eff_addr`, `eff_common` and `eff_err` keep their values between `done` strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe, taken when idle |
| addr_chars | input | 24 | Four 6-bit address characters, MSD in top bits |
| tt_inv | input | 3 | Inverted ten-thousands digit |
| common | input | 1 | 1 = common area, 0 = partition |
| ind_n | input | 1 | 0 = indirect addressing |
| idx_sel | input | 2 | 0 = no index, 1..3 = index register group |
| mem_rd | output | 1 | Read request, one cycle |
| mem_addr | output | 20 | Read address, five BCD digits |
| mem_common | output | 1 | Read area, 1 = common |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 6 | Read character |
| done | output | 1 | Result strobe |
| eff_addr | output | 20 | Effective address, five BCD digits |
| eff_common | output | 1 | Effective common bit |
| eff_err | output | 1 | Non-decimal digit seen |

## Verification
Direct requests with several inverted ten-thousands codes separate the digit mapping from the zone inversion. Indexed requests compare a sum without carry against one that crosses 9999, which shows whether a carry leaks into the ten-thousands digit. Indirect requests use fetched characters whose zone and common bits differ from the request, and one base sits at 9998. Together these show whether replacement is complete and whether the read pointer wraps. An indirect fetch followed by an index add checks the order of the two phases. A non-decimal digit and a start pulse given while the unit is busy cover the error path and the busy rule.

// File: rtl/dafu_pkg.sv
package dafu_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IND_REQ,
        ST_IND_WAIT,
        ST_IDX_REQ,
        ST_IDX_WAIT,
        ST_SUM
    } dafu_st_e;

    localparam int DIGIT_W   = 4;
    localparam int DEC_LIMIT = 9;

endpackage

// File: rtl/dafu_digit_add.sv
module dafu_digit_add
    import dafu_pkg::*;
(
    input  logic [DIGIT_W-1:0] a,
    input  logic [DIGIT_W-1:0] b,
    input  logic               cin,
    output logic [DIGIT_W-1:0] s,
    output logic               cout
);
    logic [DIGIT_W:0] raw;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b} + {{DIGIT_W{1'b0}}, cin};
        if (raw > (DIGIT_W+1)'(DEC_LIMIT)) begin
            s    = DIGIT_W'(raw - (DIGIT_W+1)'(DEC_LIMIT + 1));
            cout = 1'b1;
        end else begin
            s    = raw[DIGIT_W-1:0];
            cout = 1'b0;
        end
    end
endmodule

// File: rtl/dafu_bcd_add.sv
module dafu_bcd_add
    import dafu_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic [DIGITS*DIGIT_W-1:0] a,
    input  logic [DIGITS*DIGIT_W-1:0] b,
    output logic [DIGITS*DIGIT_W-1:0] sum,
    output logic                      cout
);
    logic [DIGITS:0] carry;

    assign carry[0] = 1'b0;
    assign cout     = carry[DIGITS];

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        dafu_digit_add u_dig (
            .a    (a[g*DIGIT_W +: DIGIT_W]),
            .b    (b[g*DIGIT_W +: DIGIT_W]),
            .cin  (carry[g]),
            .s    (sum[g*DIGIT_W +: DIGIT_W]),
            .cout (carry[g+1])
        );
    end
endmodule

// File: rtl/dafu_top.sv
module dafu_top
    import dafu_pkg::*;
#(
    parameter int DIGITS = 4,
    parameter int CHAR_W = 6,
    parameter int TT_W   = 3,
    parameter int SEL_W  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [DIGITS*CHAR_W-1:0]       addr_chars,
    input  logic [TT_W-1:0]                tt_inv,
    input  logic                           common,
    input  logic                           ind_n,
    input  logic [SEL_W-1:0]               idx_sel,
    output logic                           mem_rd,
    output logic [(DIGITS+1)*DIGIT_W-1:0]  mem_addr,
    output logic                           mem_common,
    input  logic                           mem_rvalid,
    input  logic [CHAR_W-1:0]              mem_rdata,
    output logic                           done,
    output logic [(DIGITS+1)*DIGIT_W-1:0]  eff_addr,
    output logic                           eff_common,
    output logic                           eff_err
);
    localparam int DW       = DIGITS * DIGIT_W;
    localparam int AW       = DW + DIGIT_W;
    localparam int CW_BITS  = DIGITS * CHAR_W;
    localparam int CNT_W    = (DIGITS > 1) ? $clog2(DIGITS) : 1;
    localparam int ZONE_BIT = 4;
    localparam int COM_BIT  = CHAR_W - 1;
    localparam int TT_PAD   = DIGIT_W - TT_W;

    typedef struct packed {
        dafu_st_e           st;
        logic [DW-1:0]      dig;
        logic [TT_W-1:0]    tt;
        logic               com;
        logic [SEL_W-1:0]   sel;
        logic [CNT_W-1:0]   cnt;
        logic [CW_BITS-1:0] chars;
        logic [DW-1:0]      idx;
        logic [AW-1:0]      eff;
        logic               eff_com;
        logic               err;
        logic               done;
    } dafu_reg_t;

    dafu_reg_t r_q, r_d;

    // Read pointer: base digits plus character counter
    logic          idx_phase;
    logic [DW-1:0] idx_base;
    logic [DW-1:0] ptr_a;
    logic [DW-1:0] ptr_b;
    logic [DW-1:0] ptr;
    logic          ptr_cout;
    logic [DW-1:0] sum;
    logic          sum_cout;

    assign idx_phase = (r_q.st == ST_IDX_REQ) || (r_q.st == ST_IDX_WAIT);

    always_comb begin
        idx_base          = '0;
        idx_base[3:0]     = 4'd1;
        idx_base[7:4]     = DIGIT_W'(r_q.sel);
    end

    assign ptr_a = idx_phase ? idx_base : r_q.dig;
    assign ptr_b = DW'(r_q.cnt);

    dafu_bcd_add #(.DIGITS(DIGITS)) u_ptr (
        .a    (ptr_a),
        .b    (ptr_b),
        .sum  (ptr),
        .cout (ptr_cout)
    );

    dafu_bcd_add #(.DIGITS(DIGITS)) u_sum (
        .a    (r_q.dig),
        .b    (r_q.idx),
        .sum  (sum),
        .cout (sum_cout)
    );

    // Field extraction from request and from fetched characters
    logic [DW-1:0]      in_dig;
    logic [CW_BITS-1:0] chars_new;
    logic [DW-1:0]      fet_dig;
    logic [TT_W-1:0]    fet_tt;
    logic               fet_com;
    logic               bad_dig;
    logic               bad_idx;

    assign chars_new = {r_q.chars[CW_BITS-CHAR_W-1:0], mem_rdata};

    always_comb begin
        for (int k = 0; k < DIGITS; k++) begin
            in_dig[k*DIGIT_W +: DIGIT_W]  = addr_chars[k*CHAR_W +: DIGIT_W];
            fet_dig[k*DIGIT_W +: DIGIT_W] = chars_new[k*CHAR_W +: DIGIT_W];
        end
        for (int k = 0; k < TT_W; k++) begin
            fet_tt[TT_W-1-k] = ~chars_new[(DIGITS-1-k)*CHAR_W + ZONE_BIT];
        end
        fet_com = chars_new[COM_BIT];
    end

    always_comb begin
        bad_dig = 1'b0;
        bad_idx = 1'b0;
        for (int k = 0; k < DIGITS; k++) begin
            if (r_q.dig[k*DIGIT_W +: DIGIT_W] > DIGIT_W'(DEC_LIMIT)) bad_dig = 1'b1;
            if (r_q.idx[k*DIGIT_W +: DIGIT_W] > DIGIT_W'(DEC_LIMIT)) bad_idx = 1'b1;
        end
    end

    // Next-state logic
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.dig = in_dig;
                    r_d.tt  = ~tt_inv;
                    r_d.com = common;
                    r_d.sel = idx_sel;
                    r_d.cnt = '0;
                    if (!ind_n)
                        r_d.st = ST_IND_REQ;
                    else if (idx_sel != '0)
                        r_d.st = ST_IDX_REQ;
                    else
                        r_d.st = ST_SUM;
                end
            end
            ST_IND_REQ: r_d.st = ST_IND_WAIT;
            ST_IND_WAIT: begin
                if (mem_rvalid) begin
                    r_d.chars = chars_new;
                    if (r_q.cnt == CNT_W'(DIGITS - 1)) begin
                        r_d.cnt = '0;
                        r_d.dig = fet_dig;
                        r_d.tt  = fet_tt;
                        r_d.com = fet_com;
                        r_d.st  = (r_q.sel != '0) ? ST_IDX_REQ : ST_SUM;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        r_d.st  = ST_IND_REQ;
                    end
                end
            end
            ST_IDX_REQ: r_d.st = ST_IDX_WAIT;
            ST_IDX_WAIT: begin
                if (mem_rvalid) begin
                    r_d.idx = {r_q.idx[DW-DIGIT_W-1:0], mem_rdata[DIGIT_W-1:0]};
                    if (r_q.cnt == CNT_W'(DIGITS - 1)) begin
                        r_d.cnt = '0;
                        r_d.st  = ST_SUM;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                        r_d.st  = ST_IDX_REQ;
                    end
                end
            end
            ST_SUM: begin
                r_d.eff     = {{TT_PAD{1'b0}}, r_q.tt, (r_q.sel != '0) ? sum : r_q.dig};
                r_d.eff_com = r_q.com;
                r_d.err     = bad_dig | ((r_q.sel != '0) & bad_idx);
                r_d.done    = 1'b1;
                r_d.st      = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_rd     = (r_q.st == ST_IND_REQ) || (r_q.st == ST_IDX_REQ);
    assign mem_addr   = idx_phase ? {{DIGIT_W{1'b0}}, ptr}
                                  : {{TT_PAD{1'b0}}, r_q.tt, ptr};
    assign mem_common = idx_phase ? 1'b0 : r_q.com;
    assign done       = r_q.done;
    assign eff_addr   = r_q.eff;
    assign eff_common = r_q.eff_com;
    assign eff_err    = r_q.err;

endmodule

// File: rtl/dafu_chk.sv
module dafu_chk #(
    parameter int AW = 20
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          mem_rd,
    input logic          done,
    input logic [AW-1:0] eff_addr,
    input logic          eff_common,
    input logic          eff_err
);
    logic busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (start && (!busy_q || done))
            busy_q <= 1'b1;
        else if (done)
            busy_q <= 1'b0;
    end

    assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_rd_in_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy_q);

    assert_done_in_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_q);

    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(eff_addr) && $stable(eff_common) && $stable(eff_err)));

    assert_no_rd_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_rd);
endmodule

bind dafu_top dafu_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mem_rd     (mem_rd),
    .done       (done),
    .eff_addr   (eff_addr),
    .eff_common (eff_common),
    .eff_err    (eff_err)
);

// File: tb/sim_dafu_top.sv
module sim_dafu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] addr_chars = '0;
    logic [2:0]  tt_inv = 3'b111;
    logic        common = 1'b0;
    logic        ind_n = 1'b1;
    logic [1:0]  idx_sel = '0;
    logic        mem_rd;
    logic [19:0] mem_addr;
    logic        mem_common;
    logic        mem_rvalid;
    logic [5:0]  mem_rdata;
    logic        done;
    logic [19:0] eff_addr;
    logic        eff_common;
    logic        eff_err;

    always #4 clk = ~clk;

    dafu_top u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .addr_chars(addr_chars),
        .tt_inv(tt_inv), .common(common), .ind_n(ind_n), .idx_sel(idx_sel),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_common(mem_common),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
        .eff_addr(eff_addr), .eff_common(eff_common), .eff_err(eff_err)
    );

    int errors = 0;
    int checks = 0;
    int n_push = 0;
    int n_done = 0;
    bit finished = 0;

    logic [21:0] exp_q[$];   // {err, common, addr}
    logic [20:0] rd_q[$];    // {common, addr}
    logic [5:0]  mem [int];

    function automatic logic [15:0] bcd4(input int v);
        return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    function automatic int mkey(input logic c, input logic [19:0] a);
        return int'({11'b0, c, a});
    endfunction

    function automatic logic [5:0] ch(input logic b5, input logic b4, input logic [3:0] d);
        return {b5, b4, d};
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Memory responder with read-address scoreboard
    initial begin
        bit          pend = 0;
        logic [5:0]  pdata = '0;
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 1'b0;
            if (pend) begin
                mem_rvalid = 1'b1;
                mem_rdata  = pdata;
            end
            pend = 0;
            if (mem_rd) begin
                pend = 1;
                if (rd_q.size() == 0) begin
                    chk("R4/R6", "unexpected read", {11'b0, mem_common, mem_addr}, 32'h0);
                end else begin
                    logic [20:0] e;
                    e = rd_q.pop_front();
                    chk("R4/R6", "read address", {11'b0, mem_common, mem_addr}, {11'b0, e});
                end
                pdata = mem.exists(mkey(mem_common, mem_addr)) ? mem[mkey(mem_common, mem_addr)] : 6'd0;
            end
        end
    end

    // Result monitor
    initial begin
        bit prev = 0;
        forever begin
            @(negedge clk);
            if (done) begin
                n_done++;
                checks++;
                if (prev) begin
                    errors++;
                    $display("FAIL R10 done high two cycles: actual=1 expected=0");
                end
                if (exp_q.size() == 0) begin
                    chk("R9", "extra done", 32'd1, 32'd0);
                end else begin
                    logic [21:0] e;
                    e = exp_q.pop_front();
                    chk("R2/R3/R5/R7", "eff_addr", {12'b0, eff_addr}, {12'b0, e[19:0]});
                    chk("R2/R5", "eff_common", {31'b0, eff_common}, {31'b0, e[20]});
                    chk("R8", "eff_err", {31'b0, eff_err}, {31'b0, e[21]});
                end
            end
            prev = done;
        end
    end

    task automatic go(input logic [23:0] c, input logic [2:0] ti, input logic cm,
                      input logic in_n, input logic [1:0] s, input logic [21:0] e);
        exp_q.push_back(e);
        n_push++;
        @(negedge clk);
        addr_chars = c; tt_inv = ti; common = cm; ind_n = in_n; idx_sel = s;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (n_done < n_push) @(negedge clk);
    endtask

    task automatic push_rds(input logic c, input logic [3:0] tt, input int base);
        for (int k = 0; k < 4; k++) rd_q.push_back({c, tt, bcd4((base + k) % 10000)});
    endtask

    task automatic set_idx(input int grp, input int val);
        logic [15:0] b;
        b = bcd4(val);
        for (int k = 0; k < 4; k++)
            mem[mkey(1'b0, {4'd0, bcd4(grp * 10 + 1 + k)})] = {2'b11, b[15-4*k -: 4]};
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "done", {31'b0, done}, 32'd0);
        chk("R1", "mem_rd", {31'b0, mem_rd}, 32'd0);
        chk("R1", "eff_addr", {12'b0, eff_addr}, 32'd0);
        chk("R1", "eff_common", {31'b0, eff_common}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "done after release", {31'b0, done}, 32'd0);

        // R2 R3 direct, no index: 01234 partition
        go({ch(0,1,1), ch(0,1,2), ch(0,1,3), ch(1,1,4)}, 3'b111, 1'b0, 1'b1, 2'd0,
           {1'b0, 1'b0, 4'd0, 16'h1234});
        // R3 inverted 010 -> 5, common
        go({ch(0,0,0), ch(1,0,0), ch(0,0,0), ch(0,0,7)}, 3'b010, 1'b1, 1'b1, 2'd0,
           {1'b0, 1'b1, 4'd5, 16'h0007});

        // R7 R6 index group 1 = 0005 with zone bits set; 1000 common -> 01005
        set_idx(1, 5);
        push_rds(1'b0, 4'd0, 11);
        go({ch(0,1,1), ch(0,1,0), ch(0,1,0), ch(0,1,0)}, 3'b111, 1'b1, 1'b1, 2'd1,
           {1'b0, 1'b1, 4'd0, 16'h1005});

        // R7 wrap without carry into ten-thousands: 43560 + 8000 -> 41560
        set_idx(2, 8000);
        push_rds(1'b0, 4'd0, 21);
        go({ch(0,1,3), ch(0,1,5), ch(0,1,6), ch(0,1,0)}, 3'b011, 1'b1, 1'b1, 2'd2,
           {1'b0, 1'b1, 4'd4, 16'h1560});

        // R4 R5 indirect from common 00200: fetched 27356 common
        mem[mkey(1'b1, 20'h00200)] = ch(0,1,7);
        mem[mkey(1'b1, 20'h00201)] = ch(0,0,3);
        mem[mkey(1'b1, 20'h00202)] = ch(0,1,5);
        mem[mkey(1'b1, 20'h00203)] = ch(1,1,6);
        push_rds(1'b1, 4'd0, 200);
        go({ch(0,1,0), ch(0,1,2), ch(0,1,0), ch(1,1,0)}, 3'b111, 1'b1, 1'b0, 2'd0,
           {1'b0, 1'b1, 4'd2, 16'h7356});

        // R4 R5 R6 indirect with pointer wrap at 9998, then index group 3 = 0009
        mem[mkey(1'b0, 20'h09998)] = ch(0,1,0);
        mem[mkey(1'b0, 20'h09999)] = ch(0,1,0);
        mem[mkey(1'b0, 20'h00000)] = ch(0,1,4);
        mem[mkey(1'b0, 20'h00001)] = ch(0,1,2);
        set_idx(3, 9);
        push_rds(1'b0, 4'd0, 9998);
        push_rds(1'b0, 4'd0, 31);
        go({ch(0,1,9), ch(0,1,9), ch(0,1,9), ch(0,1,8)}, 3'b111, 1'b0, 1'b0, 2'd3,
           {1'b0, 1'b0, 4'd0, 16'h0051});

        // R8 non-decimal digit passes through, flagged
        go({ch(0,1,1), ch(0,1,4'hA), ch(0,1,2), ch(0,1,3)}, 3'b110, 1'b0, 1'b1, 2'd0,
           {1'b1, 1'b0, 4'd1, 16'h1A23});

        // R11 outputs hold after done
        repeat (5) @(negedge clk);
        chk("R11", "eff_addr held", {12'b0, eff_addr}, {12'b0, 4'd1, 16'h1A23});
        chk("R11", "eff_err held", {31'b0, eff_err}, 32'd1);

        // R9 start while busy is ignored: indirect request, second pulse mid-flight
        push_rds(1'b1, 4'd0, 200);
        exp_q.push_back({1'b0, 1'b1, 4'd2, 16'h7356});
        n_push++;
        @(negedge clk);
        addr_chars = {ch(0,1,0), ch(0,1,2), ch(0,1,0), ch(1,1,0)};
        tt_inv = 3'b111; common = 1'b1; ind_n = 1'b0; idx_sel = 2'd0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        addr_chars = {ch(0,1,5), ch(0,1,5), ch(0,1,5), ch(0,1,5)};
        ind_n = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (n_done < n_push) @(negedge clk);
        repeat (8) @(negedge clk);
        chk("R9", "done count", n_done, n_push);
        chk("R4", "reads left", rd_q.size(), 0);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule